// File: doc/BRIEF.md
# Multichannel Interrupt Multiplexer

The block takes a bundle of level-sensitive, active-high interrupt source lines and presents every one of them to each of several independent output channels. Each channel holds its own enable mask. A channel's pending word is the enabled subset of the synchronized source levels. The channel's single interrupt output is high while any of its pending bits is set.

Software uses a plain 32-bit register port. Each channel has a read/write enable word and a read-only pending word, placed at a fixed stride per channel. Source lines may come from other clock domains, so they pass through a two-flop synchronizer before any masking. The output of each channel is taken from a register, so it cannot glitch.

Top module: `irq_mux_top`

## Requirements
- R1: After reset every enable word reads 0 and every bit of irq_o is 0.
- R2: The enable word of channel n is at byte address 0x10 + 0x40*n. Bit k enables source k on that channel. The word is read/write, and a read returns the last value written.
- R3: The pending word of channel n is at byte address 0x20 + 0x40*n. Bit k reads as 1 when synchronized source k is high and bit k of that channel's enable word is 1.
- R4: Pending bits follow the source level and latch nothing. When a source falls, its pending bit clears, and so does the output if no other pending bit is set.
- R5: irq_o[n] is the registered OR of channel n's pending bits. A source rise driven before clock edge 1 shows on irq_o after edge 3: two synchronizer stages, then the output register.
- R6: Writing 0 to a channel's enable word drops that channel's output on the clock edge after the write.
- R7: Writes to a pending address, to an address that is not word-exact, or to an address at or above 0x40*NUM_CH change no enable word. Reads from any unmapped address return 0.
- R8: Channels are independent. One source may raise several channels, and each channel reacts only to its own mask.
- R9: rdata_o is registered. It carries the read value in the cycle after a read request (req_i=1, we_i=0) and is 0 after any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Interrupt source levels, active high, may be asynchronous |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| irq_o | output | NUM_CH | One interrupt output per channel |

## Verification
The hardest case to reach is a change of the enable mask in the same window as a change of source level. Here the synchronizer delay and the register write race each other to reach the channel output. The stimulus first runs directed sequences that place writes and source edges a known number of cycles apart. It then runs a long phase with random source toggles and random mask writes. In that phase a behavioural model, advanced on every clock, tracks both delays and predicts the output in each cycle.

// File: rtl/irq_mux_pkg.sv
package irq_mux_pkg;
  localparam int unsigned CH_SHIFT = 6;       // 0x40 bytes per channel
  localparam logic [5:0]  EN_OFS   = 6'h10;
  localparam logic [5:0]  PEND_OFS = 6'h20;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_EN   = 2'd1,
    SEL_PEND = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irq_mux_sync.sv
module irq_mux_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/irq_mux_chan.sv
module irq_mux_chan #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic               irq_o
);
  logic irq_q;

  assign pend_o = src_i & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |pend_o;
  end

  assign irq_o = irq_q;

  // R6: a cleared mask silences the channel on the next edge
  a_r6_zero_mask_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |=> !irq_o);

  // R5: the output only rises when an enabled source was high one edge earlier
  a_r5_no_spurious_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|(src_i & en_i)));
endmodule

// File: rtl/irq_mux_regs.sv
module irq_mux_regs
  import irq_mux_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             req_i,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  input  logic [NUM_CH-1:0][NUM_SRC-1:0]   pend_i,
  output logic [NUM_CH-1:0][NUM_SRC-1:0]   en_o,
  output logic [DATA_W-1:0]                rdata_o
);
  localparam int unsigned CH_W  = ADDR_W - CH_SHIFT;
  localparam int unsigned CHS_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [CH_W-1:0]                 ch_idx;
  logic [CHS_W-1:0]                ch_lo;
  logic [5:0]                      ofs;
  logic                            in_range;
  reg_sel_e                        sel;
  logic [NUM_CH-1:0][NUM_SRC-1:0]  en_q;
  logic [DATA_W-1:0]               rd_val, rdata_q;
  logic                            rd_req, wr_en;

  assign ch_idx   = addr_i[ADDR_W-1:CH_SHIFT];
  assign ch_lo    = ch_idx[CHS_W-1:0];
  assign ofs      = addr_i[CH_SHIFT-1:0];
  assign in_range = (32'(ch_idx) < NUM_CH);

  always_comb begin
    sel = SEL_NONE;
    if (in_range) begin
      if (ofs == EN_OFS)        sel = SEL_EN;
      else if (ofs == PEND_OFS) sel = SEL_PEND;
    end
  end

  assign rd_req = req_i && !we_i;
  assign wr_en  = req_i && we_i && (sel == SEL_EN);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_en
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         en_q[c] <= '0;
      else if (wr_en && (ch_lo == CHS_W'(c))) en_q[c] <= wdata_i[NUM_SRC-1:0];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_EN:   rd_val = DATA_W'(en_q[ch_lo]);
      SEL_PEND: rd_val = DATA_W'(pend_i[ch_lo]);
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (rd_req) rdata_q <= rd_val;
    else             rdata_q <= '0;
  end

  assign en_o    = en_q;
  assign rdata_o = rdata_q;

  // R2: a mapped enable write is visible next cycle
  a_r2_en_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> (en_q[$past(ch_lo)] == $past(wdata_i[NUM_SRC-1:0])));

  // R7: no other write disturbs any mask
  a_r7_other_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && (sel != SEL_EN)) |=> $stable(en_q));

  // R9: read data returns to zero when no read was issued
  a_r9_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> (rdata_o == '0));
endmodule

// File: rtl/irq_mux_top.sv
module irq_mux_top #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [NUM_CH-1:0]  irq_o
);
  logic [NUM_SRC-1:0]              src_sync;
  logic [NUM_CH-1:0][NUM_SRC-1:0]  en, pend;

  irq_mux_sync #(.WIDTH(NUM_SRC)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (src_i),
    .q_o   (src_sync)
  );

  irq_mux_regs #(
    .NUM_SRC(NUM_SRC), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .pend_i (pend),
    .en_o   (en),
    .rdata_o(rdata_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    irq_mux_chan #(.NUM_SRC(NUM_SRC)) u_chan (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .src_i (src_sync),
      .en_i  (en[c]),
      .pend_o(pend[c]),
      .irq_o (irq_o[c])
    );
  end
endmodule

// File: tb/irq_mux_top_test.sv
module irq_mux_top_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] src = '0;
  logic        req = 0, we = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_mux_top uut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference, advanced on every clock
  logic [31:0] m_en [8];
  logic [31:0] m_s1, m_s2, m_rdata;
  logic [7:0]  m_irq;

  function automatic logic [31:0] m_read(int a);
    int ch = a / 64;
    int o  = a % 64;
    if (ch >= 8) return 0;
    if (o == 16) return m_en[ch];
    if (o == 32) return m_s2 & m_en[ch];
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 8; c++) m_en[c] = '0;
      m_s1 = '0; m_s2 = '0; m_rdata = '0; m_irq = '0;
    end else begin
      for (int c = 0; c < 8; c++) m_irq[c] = |(m_s2 & m_en[c]);
      m_rdata = (req && !we) ? m_read(int'(addr)) : 32'h0;
      if (req && we && int'(addr) < 512 && int'(addr) % 64 == 16)
        m_en[int'(addr) / 64] = wdata;
      m_s2 = m_s1;
      m_s1 = src;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check("R5 irq model", {24'h0, irq}, {24'h0, m_irq});
    check("R9 rdata model", rdata, m_rdata);
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = 12'(a); wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(int a, logic [31:0] exp, string tag);
    @(negedge clk); req = 1; we = 0; addr = 12'(a);
    @(negedge clk); req = 0;
    check(tag, rdata, exp);
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    @(negedge clk);
    check("R1 irq after reset", {24'h0, irq}, 32'h0);
    rd(16 + 64*3, 32'h0, "R1 enable reset ch3");

    wr(16, 32'hA5A5_0001);
    rd(16, 32'hA5A5_0001, "R2 readback ch0");
    wr(16 + 64*7, 32'h8000_0000);
    rd(16 + 64*7, 32'h8000_0000, "R2 readback ch7");
    wr(16, 32'h0000_00F1);
    rd(16, 32'h0000_00F1, "R2 rewrite ch0");

    // source 0 rise: driven at a negedge, then 3 edges to irq_o
    @(negedge clk); src[0] = 1;
    cyc(2);
    check("R5 irq not yet after two edges", {31'h0, irq[0]}, 32'h0);
    cyc(1);
    check("R5 irq after three edges", {31'h0, irq[0]}, 32'h1);
    rd(32, 32'h1, "R3 pending ch0");

    // R8: source 31 raises ch7 only; ch0 has bit31 clear
    @(negedge clk); src[31] = 1;
    cyc(4);
    check("R8 per-channel masks", {24'h0, irq}, 32'h81);
    rd(32 + 64*7, 32'h8000_0000, "R8 pending ch7");
    rd(32, 32'h1, "R8 pending ch0 ignores bit31");

    // R4: level drop clears, nothing latched
    @(negedge clk); src[0] = 0;
    cyc(4);
    check("R4 irq clears with level", {24'h0, irq}, 32'h80);
    rd(32, 32'h0, "R4 pending ch0 cleared");

    // R6: zero mask drops output on next edge
    wr(16 + 64*7, 32'h0);
    cyc(1);
    check("R6 zero mask silences ch7", {31'h0, irq[7]}, 32'h0);
    rd(32 + 64*7, 32'h0, "R6 pending ch7 after clear");

    // R7: ignored writes, unmapped reads
    wr(32, 32'hFFFF_FFFF);
    wr(17, 32'hFFFF_FFFF);
    wr(20, 32'hFFFF_FFFF);
    wr(512 + 16, 32'hFFFF_FFFF);
    rd(16, 32'h0000_00F1, "R7 ch0 mask untouched");
    for (int c = 1; c < 8; c++) rd(16 + 64*c, 32'h0, "R7 other masks untouched");
    rd(512 + 16, 32'h0, "R7 out-of-range read");
    rd(20, 32'h0, "R7 unmapped read");
    rd(17, 32'h0, "R7 unaligned read");
    check("R7 irq unaffected", {24'h0, irq}, 32'h0);

    // R9: idle cycle returns zero
    cyc(1);
    check("R9 idle rdata", rdata, 32'h0);

    // random phase: model compares every clock
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if ($urandom_range(3) == 0) src = $urandom();
      case ($urandom_range(3))
        0: begin req = 1; we = 1; addr = 12'(64*$urandom_range(8) + 16); wdata = $urandom(); end
        1: begin req = 1; we = 0; addr = 12'(64*$urandom_range(8) + 16*$urandom_range(2)); end
        2: begin req = 1; we = 1; addr = 12'(64*$urandom_range(7) + 32); wdata = $urandom(); end
        default: begin req = 0; we = 0; end
      endcase
    end
    @(negedge clk); req = 0; we = 0;
    cyc(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule